// File: doc/BRIEF.md
# Dual-Mode Per-Processor Counter

This block is the counter/timer owned by one processor. A mode bit, driven from a shared mode register elsewhere in the chip, selects one of two behaviours behind the same three word registers. With the bit low the block is a limit-compare timer. It counts timebase ticks, wraps at a programmed limit, latches a reached flag and raises its interrupt. With the bit high the block becomes a long free-running counter. Software writes it as two 32-bit halves, starts and stops it through a status bit, and it never interrupts.

Each timebase tick advances the count by one unit of 512, which is bit 9 of the byte-scaled value, so the low nine bits always read as zero. The counter-mode count spans value bits 30..9. The user-mode count spans value bits 62..9. Changing the mode bit has defined side effects on the running state, the interrupt, the stored limit and the count.

Top module: `dual_mode_ctr`

## Requirements
- R1: After reset, irq is 0, the status word reads 1 (running), the low word reads 0 and the high word reads 0, with the mode bit low.
- R2: In counter mode, each tick advances the count at offset 0x4. When a tick finds the count at limit minus one unit, the count returns to 0, the reached flag (bit 31) sets and irq goes to 1 on the following cycle.
- R3: In counter mode, reading offset 0x0 returns the limit in bits 30..9. That read clears the reached flag and irq. Reading offset 0x4 returns the count in bits 30..9 with the reached flag in bit 31 and has no side effect.
- R4: In counter mode, writing offset 0x0 stores data bits 30..9 as the limit, so 0xFFFFFFFF reads back as 0x7FFFFE00. The write also clears the count to 0 and lowers irq, and leaves the reached flag unchanged.
- R5: A limit of 0 makes the counter free-running; ticks advance the count but never set the reached flag or irq.
- R6: In user mode, offset 0x0 reads the count's value bits 62..32 in bits 30..0 with the reached flag in bit 31. Offset 0x4 reads value bits 31..9 with bits 8..0 zero. A carry from the low word propagates into the high word.
- R7: In user mode, writing offset 0x0 loads value bits 62..32 from data bits 30..0, and writing offset 0x4 loads value bits 31..9 from data bits 31..9. Either write clears the reached flag, and counting continues from the written value.
- R8: In user mode, writing status offset 0xC with bit 0 at 1 starts the counter and with bit 0 at 0 stops it. A stopped counter ignores ticks, and the status word reads the running state in bit 0.
- R9: In user mode irq stays 0. A tick at the all-ones count wraps it to 0 and sets the reached flag.
- R10: A rise of the mode bit lowers irq, clears the running state and sets the stored limit to its all-ones maximum, which reads 0x7FFFFE00 once counter mode returns. The count is kept.
- R11: A fall of the mode bit sets the running state and restarts the count from 0 under the stored limit.
- R12: In counter mode, writes to the status offset have no effect; the counter keeps running.
- R13: A word write in the same cycle as a tick takes the written value and drops that tick. A limit match in the same cycle as a clearing read of offset 0x0 leaves the reached flag and irq set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle timebase strobe, one per 500 ns |
| userMode | input | 1 | Mode bit from the shared mode register: 1 user counter, 0 limit timer |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe (carries the read side effects) |
| addr | input | 4 | Byte offset; only word-aligned offsets 0x0, 0x4, 0xC decode |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data for addr, combinational from current state |
| irq | output | 1 | Timer interrupt, level |

## Verification
Two collisions get their own cycle. In the first, a tick arrives exactly when the count sits one unit below the limit while a read of offset 0x0 is also strobed. The bench raises both in one cycle and expects irq and the reached flag to survive the clearing read. In the second, a user-mode low-word write shares a cycle with a tick. The bench expects the written value with no extra unit added, then one more tick to show counting continues from it.

// File: rtl/dual_mode_ctr_pkg.sv
package dual_mode_ctr_pkg;

  // word index taken from addr[3:2]
  typedef enum logic [1:0] {
    SEL_HIGH  = 2'd0,
    SEL_LOW   = 2'd1,
    SEL_SPARE = 2'd2,
    SEL_CTRL  = 2'd3
  } wordSel_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clrCnt;
    logic ldHigh;
    logic ldLow;
    logic ldLim;
    logic maxLim;
    logic step;
  } dpCmd_t;

endpackage

// File: rtl/dual_mode_ctr_dp.sv
module dual_mode_ctr_dp
  import dual_mode_ctr_pkg::*;
#(
  parameter int CNT_W      = 63,
  parameter int LIM_W      = 31,
  parameter int TICK_SHIFT = 9,
  localparam int TICK_W    = CNT_W - TICK_SHIFT,
  localparam int CMP_W     = LIM_W - TICK_SHIFT,
  localparam int LO_W      = 32 - TICK_SHIFT,
  localparam int HI_W      = TICK_W - LO_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCmd_t            cmd,
  input  logic [31:0]       wrData,
  input  logic              userMode,
  output logic [TICK_W-1:0] cntQ,
  output logic [CMP_W-1:0]  limQ,
  output logic              hitEvt
);

  logic [CMP_W-1:0] limEff;
  logic             wrapNow;

  // a zero limit behaves as the widest possible period
  assign limEff = (limQ == '0) ? '1 : limQ;

  always_comb begin
    if (userMode) wrapNow = &cntQ;
    else          wrapNow = (cntQ[CMP_W-1:0] == limEff - 1'b1);
  end

  // a wrap counts as a hit except in free-running counter mode
  assign hitEvt = wrapNow & (userMode | (limQ != '0));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntQ <= '0;
      limQ <= '0;
    end else begin
      if (cmd.clrCnt)      cntQ <= '0;
      else if (cmd.ldHigh) cntQ[TICK_W-1:LO_W] <= wrData[HI_W-1:0];
      else if (cmd.ldLow)  cntQ[LO_W-1:0] <= wrData[31:TICK_SHIFT];
      else if (cmd.step)   cntQ <= (wrapNow && !userMode) ? '0 : cntQ + 1'b1;

      if (cmd.maxLim)     limQ <= '1;
      else if (cmd.ldLim) limQ <= wrData[LIM_W-1:TICK_SHIFT];
    end
  end

endmodule

// File: rtl/dual_mode_ctr_ctrl.sv
module dual_mode_ctr_ctrl
  import dual_mode_ctr_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic              userMode,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrBit0,
  input  logic              hitEvt,
  output dpCmd_t            cmd,
  output logic              runQ,
  output logic              reachedQ,
  output logic              irq
);

  logic     modeQ, modeEdge, aligned;
  logic     wrHi, wrLo, wrSt, rdHi, hitNow;
  wordSel_t sel;

  assign sel      = wordSel_t'(addr[3:2]);
  assign aligned  = (addr[1:0] == 2'b00) && (addr[ADDR_W-1:2] < 3'(4));
  assign wrHi     = wrEn & aligned & (sel == SEL_HIGH);
  assign wrLo     = wrEn & aligned & (sel == SEL_LOW);
  assign wrSt     = wrEn & aligned & (sel == SEL_CTRL);
  assign rdHi     = rdEn & aligned & (sel == SEL_HIGH);
  assign modeEdge = userMode ^ modeQ;

  always_comb begin
    cmd        = '0;
    cmd.ldHigh = wrHi & userMode & ~modeEdge;
    cmd.ldLow  = wrLo & userMode & ~modeEdge;
    cmd.ldLim  = wrHi & ~userMode & ~modeEdge;
    cmd.clrCnt = cmd.ldLim | (modeEdge & ~userMode);
    cmd.maxLim = modeEdge & userMode;
    cmd.step   = tick & runQ & ~modeEdge & ~cmd.ldHigh & ~cmd.ldLow & ~cmd.ldLim;
  end

  assign hitNow = cmd.step & hitEvt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ    <= 1'b0;
      runQ     <= 1'b1;
      reachedQ <= 1'b0;
      irq      <= 1'b0;
    end else begin
      modeQ <= userMode;

      if (modeEdge)              runQ <= ~userMode;
      else if (wrSt && userMode) runQ <= wrBit0;

      if (hitNow)                          reachedQ <= 1'b1;
      else if (cmd.ldHigh || cmd.ldLow)    reachedQ <= 1'b0;
      else if (rdHi && !userMode)          reachedQ <= 1'b0;

      if (hitNow && !userMode)                                 irq <= 1'b1;
      else if (cmd.maxLim || cmd.ldLim || (rdHi && !userMode)) irq <= 1'b0;
    end
  end

endmodule

// File: rtl/dual_mode_ctr.sv
module dual_mode_ctr
  import dual_mode_ctr_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int CNT_W      = 63,
  parameter int LIM_W      = 31,
  parameter int TICK_SHIFT = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic              userMode,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wrData,
  output logic [31:0]       rdData,
  output logic              irq
);

  localparam int TICK_W = CNT_W - TICK_SHIFT;
  localparam int CMP_W  = LIM_W - TICK_SHIFT;
  localparam int LO_W   = 32 - TICK_SHIFT;

  dpCmd_t            cmd;
  logic [TICK_W-1:0] cntQ;
  logic [CMP_W-1:0]  limQ;
  logic              hitEvt, runQ, reachedQ;

  dual_mode_ctr_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .tick(tick), .userMode(userMode),
    .wrEn(wrEn), .rdEn(rdEn), .addr(addr), .wrBit0(wrData[0]),
    .hitEvt(hitEvt), .cmd(cmd), .runQ(runQ), .reachedQ(reachedQ), .irq(irq)
  );

  dual_mode_ctr_dp #(.CNT_W(CNT_W), .LIM_W(LIM_W), .TICK_SHIFT(TICK_SHIFT)) u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .wrData(wrData), .userMode(userMode),
    .cntQ(cntQ), .limQ(limQ), .hitEvt(hitEvt)
  );

  always_comb begin
    rdData = '0;
    if (addr[1:0] == 2'b00 && addr[ADDR_W-1:2] < 3'(4)) begin
      unique case (wordSel_t'(addr[3:2]))
        SEL_HIGH:
          if (userMode) rdData = {reachedQ, cntQ[TICK_W-1:LO_W]};
          else          rdData = 32'({limQ, {TICK_SHIFT{1'b0}}});
        SEL_LOW:
          if (userMode) rdData = {cntQ[LO_W-1:0], {TICK_SHIFT{1'b0}}};
          else          rdData = {reachedQ, 31'({cntQ[CMP_W-1:0], {TICK_SHIFT{1'b0}}})};
        SEL_CTRL:  rdData = {31'b0, runQ};
        SEL_SPARE: rdData = '0;
      endcase
    end
  end

endmodule

// File: rtl/dual_mode_ctr_chk.sv
module dual_mode_ctr_chk #(
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              tick,
  input logic              userMode,
  input logic              wrEn,
  input logic              rdEn,
  input logic [ADDR_W-1:0] addr,
  input logic              irq,
  input logic              runQ
);

  // R2: the interrupt only ever rises on a tick
  a_r2_irq_on_tick: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> $past(tick));

  // R3: a limit read with no tick present clears the interrupt
  a_r3_read_clears: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && addr == '0 && !userMode && !tick) |=> !irq);

  // R4: a limit write lowers the interrupt
  a_r4_limit_lowers: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == '0 && !userMode) |=> !irq);

  // R9: user mode never interrupts
  a_r9_user_quiet: assert property (@(posedge clk) disable iff (!rstN)
    userMode |=> !irq);

  // R10: entering user mode stops the counter
  a_r10_enter_stops: assert property (@(posedge clk) disable iff (!rstN)
    $rose(userMode) |=> !runQ);

  // R11: leaving user mode starts the counter
  a_r11_leave_runs: assert property (@(posedge clk) disable iff (!rstN)
    $fell(userMode) |=> runQ);

  // R12: in counter mode the counter keeps running whatever is written
  a_r12_counter_runs: assert property (@(posedge clk) disable iff (!rstN)
    !userMode |=> (runQ || userMode));

endmodule

bind dual_mode_ctr dual_mode_ctr_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .tick(tick), .userMode(userMode), .wrEn(wrEn),
  .rdEn(rdEn), .addr(addr), .irq(irq), .runQ(runQ)
);

// File: tb/dual_mode_ctr_bench.sv
module dual_mode_ctr_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tick = 1'b0;
  logic        userMode = 1'b0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        irq;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 0;

  always #10 clk = ~clk;

  dual_mode_ctr u_dual_mode_ctr (
    .clk(clk), .rstN(rstN), .tick(tick), .userMode(userMode), .wrEn(wrEn),
    .rdEn(rdEn), .addr(addr), .wrData(wrData), .rdData(rdData), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wrReg(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic rdReg(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); rdEn = 1'b1; addr = a;
    #1 d = rdData;
    @(negedge clk); rdEn = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic setMode(input logic m);
    @(negedge clk); userMode = m;
    @(negedge clk);
  endtask

  task automatic testReset();
    logic [31:0] d;
    chk("R1 irq", 32'(irq), 32'h0);
    rdReg(4'hC, d); chk("R1 status", d, 32'h1);
    rdReg(4'h4, d); chk("R1 low", d, 32'h0);
    rdReg(4'h0, d); chk("R1 high", d, 32'h0);
  endtask

  task automatic testLimitMatch();
    logic [31:0] d;
    wrReg(4'h0, 32'h600);
    ticks(2);
    rdReg(4'h4, d); chk("R2 count", d, 32'h400);
    ticks(1);
    chk("R2 irq", 32'(irq), 32'h1);
    rdReg(4'h4, d); chk("R3 low reached", d, 32'h8000_0000);
    chk("R3 low read keeps irq", 32'(irq), 32'h1);
    rdReg(4'h0, d); chk("R3 limit", d, 32'h600);
    chk("R3 irq cleared", 32'(irq), 32'h0);
    rdReg(4'h4, d); chk("R3 reached cleared", d, 32'h0);
  endtask

  task automatic testLimitWrite();
    logic [31:0] d;
    ticks(3);
    chk("R4 irq before", 32'(irq), 32'h1);
    wrReg(4'h0, 32'h800);
    chk("R4 irq lowered", 32'(irq), 32'h0);
    rdReg(4'h4, d); chk("R4 count cleared reached kept", d, 32'h8000_0000);
    rdReg(4'h0, d); chk("R4 limit", d, 32'h800);
    wrReg(4'h0, 32'hFFFF_FFFF);
    rdReg(4'h0, d); chk("R4 masked", d, 32'h7FFF_FE00);
  endtask

  task automatic testFreeRun();
    logic [31:0] d;
    wrReg(4'h0, 32'h0);
    ticks(5);
    rdReg(4'h4, d); chk("R5 count", d, 32'hA00);
    chk("R5 irq", 32'(irq), 32'h0);
  endtask

  task automatic testMatchVsRead();
    logic [31:0] d;
    wrReg(4'h0, 32'h400);
    ticks(1);
    @(negedge clk); tick = 1'b1; rdEn = 1'b1; addr = 4'h0;
    #1 d = rdData;
    @(negedge clk); tick = 1'b0; rdEn = 1'b0;
    chk("R13 read data", d, 32'h400);
    chk("R13 irq survives", 32'(irq), 32'h1);
    rdReg(4'h4, d); chk("R13 reached survives", d, 32'h8000_0000);
  endtask

  task automatic testStatusIgnored();
    logic [31:0] d;
    wrReg(4'hC, 32'h0);
    rdReg(4'hC, d); chk("R12 status", d, 32'h1);
    ticks(1);
    rdReg(4'h4, d); chk("R12 still counts", d, 32'h8000_0200);
  endtask

  task automatic testEnterUser();
    logic [31:0] d;
    setMode(1'b1);
    chk("R10 irq lowered", 32'(irq), 32'h0);
    rdReg(4'hC, d); chk("R10 stopped", d, 32'h0);
    ticks(2);
    rdReg(4'h4, d); chk("R10 count kept", d, 32'h200);
  endtask

  task automatic testUserWords();
    logic [31:0] d;
    wrReg(4'h0, 32'h9234_5678);
    wrReg(4'h4, 32'hABCD_EFFF);
    rdReg(4'h4, d); chk("R7 low", d, 32'hABCD_EE00);
    rdReg(4'h0, d); chk("R7 high reached cleared", d, 32'h1234_5678);
  endtask

  task automatic testStartStop();
    logic [31:0] d;
    wrReg(4'hC, 32'h1);
    rdReg(4'hC, d); chk("R8 running", d, 32'h1);
    ticks(3);
    rdReg(4'h4, d); chk("R8 advanced", d, 32'hABCD_F400);
    wrReg(4'hC, 32'h0);
    ticks(2);
    rdReg(4'h4, d); chk("R8 held", d, 32'hABCD_F400);
    rdReg(4'hC, d); chk("R8 stopped", d, 32'h0);
  endtask

  task automatic testCarry();
    logic [31:0] d;
    wrReg(4'h4, 32'hFFFF_FE00);
    wrReg(4'h0, 32'h5);
    wrReg(4'hC, 32'h1);
    ticks(1);
    rdReg(4'h4, d); chk("R6 low wrapped", d, 32'h0);
    rdReg(4'h0, d); chk("R6 carry", d, 32'h6);
  endtask

  task automatic testUserWrap();
    logic [31:0] d;
    wrReg(4'h0, 32'h7FFF_FFFF);
    wrReg(4'h4, 32'hFFFF_FE00);
    ticks(1);
    rdReg(4'h0, d); chk("R9 high reached", d, 32'h8000_0000);
    rdReg(4'h4, d); chk("R9 low zero", d, 32'h0);
    chk("R9 irq", 32'(irq), 32'h0);
  endtask

  task automatic testWriteVsTick();
    logic [31:0] d;
    @(negedge clk); wrEn = 1'b1; addr = 4'h4; wrData = 32'h1000; tick = 1'b1;
    @(negedge clk); wrEn = 1'b0; tick = 1'b0;
    rdReg(4'h4, d); chk("R13 write wins", d, 32'h1000);
    ticks(1);
    rdReg(4'h4, d); chk("R7 continues", d, 32'h1200);
  endtask

  task automatic testLeaveUser();
    logic [31:0] d;
    setMode(1'b0);
    rdReg(4'hC, d); chk("R11 running", d, 32'h1);
    rdReg(4'h4, d); chk("R11 count restart", d, 32'h0);
    rdReg(4'h0, d); chk("R10 limit max", d, 32'h7FFF_FE00);
    ticks(3);
    rdReg(4'h4, d); chk("R11 counts", d, 32'h600);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testLimitMatch();
    testLimitWrite();
    testFreeRun();
    testMatchVsRead();
    testStatusIgnored();
    testEnterUser();
    testUserWords();
    testStartStop();
    testCarry();
    testUserWrap();
    testWriteVsTick();
    testLeaveUser();
    finishRun();
  end

  initial begin
    repeat (20000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual hung expected finished");
    finishRun();
  end

endmodule